// File: doc/BRIEF.md
# Four-Queue Priority Classifier and Weighted Round-Robin Scheduler

This block serves one output port of a packet switch. Each cycle it may accept one packet descriptor, sort it into one of four descriptor queues of rising priority, and hand one descriptor per cycle to the downstream side. The sort uses the descriptor's VLAN tag priority (when a tag is present) and a per-ingress-port high-priority configuration mask. Frame storage and tag parsing happen elsewhere. The block only moves opaque descriptor tokens.

The input side is a plain valid strobe with no back-pressure. A descriptor that arrives when its target queue already holds its full depth is discarded, and a one-cycle drop pulse reports the loss. The output side is valid/ready. `out_valid` is high whenever any queue holds a descriptor, and a transfer happens on every clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, nothing is removed. The offered descriptor may still change during a stall, because a new arrival can change which queue the scheduler selects, so the consumer must sample it only in the transfer cycle. Queues are served by weighted round-robin. Only queues that currently hold descriptors are considered.

Top module: `prio_qsched`

## Requirements
- R1: A descriptor goes to queue 0 when it has no usable tag priority and enters on a normal port. This covers `in_tagged`=0, or `in_tagged`=1 with `in_tag_pri`=0, on a port whose bit `hi_port_mask[in_port]` is 0.
- R2: A tagged descriptor with nonzero priority is sorted by that priority whatever its port: priorities 1 and 2 go to queue 1, priorities 3 to 5 go to queue 2, and priorities 6 and 7 go to queue 3.
- R3: A descriptor without a nonzero tag priority that enters on a port whose mask bit is 1 goes to queue 2.
- R4: `out_valid` is 1 exactly when some queue holds a descriptor. `out_queue` (0 to 3) names the queue offered, and `out_desc` is that queue's oldest entry. Exactly one descriptor is removed on each edge where `out_valid` and `out_ready` are both 1.
- R5: The scheduler grants queue q at most 1, 2, 4 or 8 times per visit, for q = 0, 1, 2 and 3 respectively. Visits run in the order 3, 2, 1, 0 and then wrap back to 3. Empty queues are skipped. After reset the first visit goes to the highest nonempty queue.
- R6: A grant that takes the only entry stored in a queue ends that queue's visit, and its unused grants are forfeited even if a new descriptor arrives in the same cycle.
- R7: Each queue keeps its descriptors in arrival order and stores up to 8 entries.
- R8: A descriptor that arrives while its target queue holds 8 entries is discarded, even if that queue is being read in the same cycle. `drop` is then 1 for exactly the following cycle.
- R9: After reset `out_valid` and `drop` are 0. A descriptor accepted at an edge is offered on `out_valid` from that edge onward, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor present this cycle |
| in_desc | input | DESC_W | Descriptor token |
| in_tagged | input | 1 | Frame carries a VLAN tag |
| in_tag_pri | input | 3 | Tag priority field |
| in_port | input | clog2(NUM_PORTS) | Ingress port number |
| hi_port_mask | input | NUM_PORTS | Bit p set: port p is high priority |
| out_valid | output | 1 | A descriptor is offered |
| out_ready | input | 1 | Downstream accepts the offered descriptor |
| out_desc | output | DESC_W | Offered descriptor |
| out_queue | output | 2 | Queue the offered descriptor came from |
| drop | output | 1 | Pulse: previous cycle's arrival was discarded |

## Verification
Arrival and removal can hit the same queue in the same cycle. The sharpest case is a descriptor arriving at a full queue on the same edge that the queue is read. The bench provokes this by filling queue 0, then raising `in_valid` and `out_ready` together. The result is judged by the drop pulse and by draining the queue: exactly seven older descriptors must come out, in order, and neither the new arrival nor the earlier overflow may appear. A second collision refills a queue on the edge that empties it, and the next grant must go to another queue, which shows that the credit was forfeited.

// File: rtl/qsched_pkg.sv
package qsched_pkg;
  localparam int NUM_Q    = 4;
  localparam int QSEL_W   = 2;
  localparam int CREDIT_W = 4;

  typedef logic [QSEL_W-1:0] qsel_t;

  // grants per visit: 1, 2, 4, 8 from lowest to highest queue
  function automatic logic [CREDIT_W-1:0] q_weight(qsel_t q);
    return CREDIT_W'(1) << q;
  endfunction
endpackage

// File: rtl/prio_classify.sv
module prio_classify
  import qsched_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 tagged_i,
  input  logic [2:0]           tag_pri_i,
  input  logic [PORT_W-1:0]    port_i,
  input  logic [NUM_PORTS-1:0] hi_mask_i,
  output qsel_t                q_o
);
  logic hi_port;
  assign hi_port = hi_mask_i[port_i];

  always_comb begin
    q_o = qsel_t'(0);
    if (tagged_i && tag_pri_i != 3'd0) begin
      unique case (tag_pri_i)
        3'd1, 3'd2:       q_o = qsel_t'(1);
        3'd3, 3'd4, 3'd5: q_o = qsel_t'(2);
        default:          q_o = qsel_t'(3);
      endcase
    end else if (hi_port) begin
      q_o = qsel_t'(2);
    end
  end
endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R7: occupancy never exceeds the depth
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R4: reads are only requested from a queue that holds data
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R8: a write attempted at full leaves occupancy unchanged unless a read occurs
  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/wrr_sched.sv
module wrr_sched
  import qsched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] nonempty,
  input  logic [NUM_Q-1:0] last_one,
  input  logic             grant,
  output qsel_t            sel
);
  qsel_t               cur, nxt;
  logic [CREDIT_W-1:0] credit;
  logic                keep;

  always_comb begin
    keep = nonempty[cur] && (credit != '0);
    nxt  = cur;
    // visit order descends and wraps: cur-1, cur-2, cur-3, then cur itself
    for (int k = NUM_Q; k >= 1; k--) begin
      if (nonempty[qsel_t'(int'(cur) - k)]) nxt = qsel_t'(int'(cur) - k);
    end
    sel = keep ? cur : nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      credit <= '0;
    end else if (grant) begin
      cur <= sel;
      if (last_one[sel])  credit <= '0;
      else if (keep)      credit <= credit - CREDIT_W'(1);
      else                credit <= q_weight(nxt) - CREDIT_W'(1);
    end
  end

  // R5: remaining credit never exceeds the largest weight minus one
  a_r5_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= q_weight(qsel_t'(NUM_Q - 1)) - CREDIT_W'(1));
  // R5: when anything is pending the selected queue holds data
  a_r5_sel_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (|nonempty) |-> nonempty[sel]);
  // R6: taking a queue's only entry leaves no credit behind
  a_r6_forfeit: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && last_one[sel]) |=> (credit == '0));
endmodule

// File: rtl/prio_qsched.sv
module prio_qsched
  import qsched_pkg::*;
#(
  parameter int DESC_W    = 16,
  parameter int NUM_PORTS = 16,
  parameter int QDEPTH    = 8,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DESC_W-1:0]    in_desc,
  input  logic                 in_tagged,
  input  logic [2:0]           in_tag_pri,
  input  logic [PORT_W-1:0]    in_port,
  input  logic [NUM_PORTS-1:0] hi_port_mask,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DESC_W-1:0]    out_desc,
  output logic [1:0]           out_queue,
  output logic                 drop
);
  qsel_t             tgt_q, sel;
  logic [NUM_Q-1:0]  push, pop, full, empty, last_one;
  logic [DESC_W-1:0] head [NUM_Q];
  logic [CNT_W-1:0]  cnt  [NUM_Q];
  logic              grant;

  prio_classify #(.NUM_PORTS(NUM_PORTS)) u_cls (
    .tagged_i (in_tagged),
    .tag_pri_i(in_tag_pri),
    .port_i   (in_port),
    .hi_mask_i(hi_port_mask),
    .q_o      (tgt_q)
  );

  assign out_valid = |(~empty);
  assign grant     = out_valid && out_ready;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign push[q]     = in_valid && (tgt_q == qsel_t'(q)) && !full[q];
    assign pop[q]      = grant && (sel == qsel_t'(q));
    assign last_one[q] = (cnt[q] == CNT_W'(1));

    desc_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push[q]),
      .din  (in_desc),
      .pop  (pop[q]),
      .dout (head[q]),
      .count(cnt[q]),
      .full (full[q]),
      .empty(empty[q])
    );
  end

  wrr_sched u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .nonempty(~empty),
    .last_one(last_one),
    .grant   (grant),
    .sel     (sel)
  );

  assign out_desc  = head[sel];
  assign out_queue = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop <= 1'b0;
    else        drop <= in_valid && full[tgt_q];
  end

  // R4: at most one queue is read per cycle
  a_r4_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));
  // R4: the offered queue holds data whenever something is offered
  a_r4_offer_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !empty[out_queue]);
  // R8: a drop pulse follows an arrival at a full queue and lasts one cycle
  a_r8_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop) |-> $past(in_valid));
  // R9: a fresh arrival into an idle block is offered on the next cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && in_valid) |=> out_valid);
endmodule

// File: tb/test_prio_qsched.sv
`timescale 1ns/1ps
module test_prio_qsched;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_desc = '0;
  logic          in_tagged = 1'b0;
  logic [2:0]    in_tag_pri = '0;
  logic [3:0]    in_port = '0;
  logic [15:0]   hi_port_mask = 16'h1020;  // ports 5 and 12 are high priority
  logic          out_valid, out_ready = 1'b0, drop;
  logic [DW-1:0] out_desc;
  logic [1:0]    out_queue;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  prio_qsched i_prio_qsched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_desc(in_desc),
    .in_tagged(in_tagged), .in_tag_pri(in_tag_pri), .in_port(in_port),
    .hi_port_mask(hi_port_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_desc(out_desc), .out_queue(out_queue), .drop(drop)
  );

  // {tagged, pri[2:0], port[3:0], expected queue[1:0]}
  localparam logic [9:0] VEC [16] = '{
    {1'b0, 3'd0, 4'd0,  2'd0},  // R1 untagged normal port
    {1'b0, 3'd0, 4'd5,  2'd2},  // R3 untagged high port
    {1'b0, 3'd0, 4'd12, 2'd2},  // R3
    {1'b0, 3'd0, 4'd13, 2'd0},  // R1
    {1'b1, 3'd0, 4'd1,  2'd0},  // R1 tagged priority 0
    {1'b1, 3'd1, 4'd1,  2'd1},  // R2
    {1'b1, 3'd2, 4'd2,  2'd1},  // R2
    {1'b1, 3'd3, 4'd3,  2'd2},  // R2
    {1'b1, 3'd4, 4'd4,  2'd2},  // R2
    {1'b1, 3'd5, 4'd6,  2'd2},  // R2
    {1'b1, 3'd6, 4'd7,  2'd3},  // R2
    {1'b1, 3'd7, 4'd8,  2'd3},  // R2
    {1'b1, 3'd0, 4'd5,  2'd2},  // R3 tag priority 0 on high port
    {1'b1, 3'd1, 4'd12, 2'd1},  // R2 tag wins over high port
    {1'b1, 3'd7, 4'd5,  2'd3},  // R2
    {1'b0, 3'd0, 4'd15, 2'd0}   // R1
  };

  task automatic check(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic push(bit tg, logic [2:0] pr, logic [3:0] pt, logic [DW-1:0] d);
    in_valid = 1'b1; in_tagged = tg; in_tag_pri = pr; in_port = pt; in_desc = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_q(int q, logic [DW-1:0] d);
    case (q)
      0: push(1'b0, 3'd0, 4'd0, d);
      1: push(1'b1, 3'd1, 4'd0, d);
      2: push(1'b1, 3'd3, 4'd0, d);
      default: push(1'b1, 3'd7, 4'd0, d);
    endcase
  endtask

  task automatic pop1();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  localparam int SEQ [32] = '{3,3,3,3,3,3,3,3, 2,2,2,2, 1,1, 0,
                              2,2,2,2, 1,1, 0, 1,1, 0, 1,1, 0, 0,0,0,0};

  initial begin
    int seen [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    check(drop == 1'b0, "R9 reset drop", drop, 0);

    // classification vectors (R1 R2 R3), latency (R9)
    for (int i = 0; i < 16; i++) begin
      in_valid = 1'b1; in_tagged = VEC[i][9]; in_tag_pri = VEC[i][8:6];
      in_port = VEC[i][5:2]; in_desc = DW'(i);
      #1 check(out_valid == 1'b0, "R9 not before edge", out_valid, 0);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R9 offered after edge", out_valid, 1);
      check(out_queue == VEC[i][1:0], "R1/R2/R3 queue", out_queue, VEC[i][1:0]);
      check(out_desc == DW'(i), "R4 desc", out_desc, i);
      pop1();
      check(out_valid == 1'b0, "R4 removed", out_valid, 0);
    end

    // full weighted round: 8 entries per queue (R5 R7)
    for (int q = 0; q < 4; q++)
      for (int n = 0; n < 8; n++) push_q(q, DW'(q * 256 + n));
    check(out_valid == 1'b1, "R4 stalled hold", out_valid, 1);
    out_ready = 1'b1;
    for (int i = 0; i < 32; i++) begin
      check(out_queue == 2'(SEQ[i]), "R5 wrr order", out_queue, SEQ[i]);
      check(out_desc == DW'(SEQ[i] * 256 + seen[SEQ[i]]), "R7 fifo order",
            out_desc, SEQ[i] * 256 + seen[SEQ[i]]);
      seen[SEQ[i]]++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R4 drained", out_valid, 0);

    // forfeit when a queue empties (R6)
    push_q(3, 16'h0300); push_q(3, 16'h0301);
    push_q(0, 16'h0000); push_q(0, 16'h0001);
    pop1();
    check(out_queue == 2'd3, "R5 stays on q3", out_queue, 3);
    // refill q3 on the edge that takes its last entry
    in_valid = 1'b1; in_tagged = 1'b1; in_tag_pri = 3'd7; in_port = '0;
    in_desc = 16'h0302; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    check(out_queue == 2'd0, "R6 forfeit moves on", out_queue, 0);
    check(out_desc == 16'h0000, "R6 q0 head", out_desc, 16'h0000);
    pop1();
    check(out_queue == 2'd3, "R5 wrap to q3", out_queue, 3);
    check(out_desc == 16'h0302, "R7 q3 refill", out_desc, 16'h0302);
    pop1();
    pop1();
    check(out_valid == 1'b0, "R4 empty again", out_valid, 0);

    // overflow (R8)
    for (int n = 0; n < 8; n++) push_q(0, DW'(16'h0100 + n));
    check(drop == 1'b0, "R8 no drop below full", drop, 0);
    push_q(0, 16'h0108);
    check(drop == 1'b1, "R8 drop pulse", drop, 1);
    @(negedge clk);
    check(drop == 1'b0, "R8 pulse one cycle", drop, 0);
    // arrival at full queue while it is being read
    in_valid = 1'b1; in_tagged = 1'b0; in_port = '0; in_desc = 16'h01ff;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    check(drop == 1'b1, "R8 drop with same-cycle read", drop, 1);
    for (int n = 1; n < 8; n++) begin
      check(out_valid && out_desc == DW'(16'h0100 + n), "R8 survivors",
            out_desc, 16'h0100 + n);
      pop1();
    end
    check(out_valid == 1'b0, "R8 discarded not stored", out_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule